// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a Repeated START condition on an open-drain I2C bus. A command write with the repeated-start request bit set launches the sequence. The request is taken only when the sequencer is idle and no other bus event is in progress. The block then works through a fixed order of steps:

1. It pulls SCL low.
2. It releases SDA for one baud period.
3. It releases SCL and waits for SCL to read high.
4. It holds both lines high for one baud period.
5. It pulls SDA low for one baud period while SCL stays high.

Each step waits until the line is read back at the level it expects. A 7-bit down-counter, loaded from a reload input, times the steps.

At the end the block clears the request bit, raises an interrupt flag and keeps SDA pulled low, so that a separate transmitter can take over. A start-detected flag rises as soon as SDA is seen falling while SCL is high. Two bus-collision cases abort the sequence: both lines are released, the request bit is cleared and a collision flag is set.

While the sequence runs, writes to the command bits have no effect. A write to the transmit buffer during the sequence sets a write-collision flag and leaves the buffer unchanged. A request that is accepted clears all four flags.

Top module: `rs_top`

## Requirements
- R1: After reset, both line drives are released, all four flags are 0, the command bits read 0 and the buffer reads 0.
- R2: A request (command write with bit 1 set) is ignored while `otherBusy` is high. Bit 1 of the command bits stays 0 and SCL is not driven.
- R3: With reload value R and no stretching, counted from the accepting edge k=0: SCL is driven low after edge 0, SCL is released after edge R+2, and SDA is driven low after edge 2R+4.
- R4: If SCL is held low by another device after being released, the high-period count starts only once SCL reads high. All later steps shift by the stretch length.
- R5: The start-detected flag is set one cycle after SDA is seen falling while SCL is high.
- R6: After edge 3R+5 the interrupt flag is 1 and command bit 1 is 0, and SDA stays driven low until the next accepted request.
- R7: If SDA reads low when the released SCL reads high, the block sets the bus-collision flag in the next cycle. It also releases both lines, clears command bit 1 and leaves the interrupt flag at 0.
- R8: If SCL reads low during the both-high period, before SDA is driven, the block sets the bus-collision flag with the same release and clear as in R7.
- R9: A buffer write while the sequence is busy sets the write-collision flag and leaves the buffer value unchanged. A buffer write while idle stores the data.
- R10: Command writes while busy leave all five command bits unchanged, apart from the automatic clear of bit 1.
- R11: An accepted request clears the start-detected, interrupt, bus-collision and write-collision flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadVal | input | 7 | Baud counter reload value; one period is reloadVal+1 cycles |
| otherBusy | input | 1 | Another bus event is in progress |
| cmdWrite | input | 1 | Write strobe for the command bits |
| cmdData | input | 5 | Command bits to write; bit 1 is the repeated-start request |
| cmdBits | output | 5 | Current command bits |
| bufWrite | input | 1 | Write strobe for the transmit buffer |
| bufData | input | 8 | Transmit buffer write data |
| bufOut | output | 8 | Transmit buffer contents |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| startSeen | output | 1 | START condition detected on the lines |
| irqFlag | output | 1 | Sequence completed |
| bcolFlag | output | 1 | Bus collision detected |
| wcolFlag | output | 1 | Buffer written while busy |

## Verification
Some properties are checked on every cycle:
- SDA is never driven while SCL is driven.
- Command and buffer writes made while busy change nothing.
- Completion leaves SDA held with no collision.
- A collision releases both lines.
- The start-detected flag rises only after an SDA fall with SCL high.
- A request that is ignored drives no line.

Only the bench scenarios can show the exact cycle of each line change for different reload values. They also show the shift caused by clock stretching and the abort timing of each of the two collision cases.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int CMD_W   = 5;
  localparam int REQ_BIT = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PULL_SCL,
    S_SDA_REL,
    S_SCL_REL,
    S_BOTH_HI,
    S_SDA_LOW
  } seqState_t;

  typedef struct packed {
    logic accept;
    logic loadCnt;
    logic setIrq;
    logic setBcol;
    logic clrReq;
  } dpCtl_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqWrite,
  input  logic   otherBusy,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   timeout,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   sclDriveLow,
  output logic   sdaDriveLow
);
  seqState_t state, stateNext;
  logic holdSda, holdSdaNext;

  always_comb begin
    stateNext   = state;
    holdSdaNext = holdSda;
    ctl         = '0;
    case (state)
      S_IDLE: begin
        if (reqWrite && !otherBusy) begin
          ctl.accept  = 1'b1;
          holdSdaNext = 1'b0;
          stateNext   = S_PULL_SCL;
        end
      end
      S_PULL_SCL: begin
        if (!sclIn) begin
          ctl.loadCnt = 1'b1;
          stateNext   = S_SDA_REL;
        end
      end
      S_SDA_REL: begin
        if (timeout && sdaIn) stateNext = S_SCL_REL;
      end
      S_SCL_REL: begin
        if (sclIn) begin
          if (!sdaIn) begin
            ctl.setBcol = 1'b1;
            ctl.clrReq  = 1'b1;
            holdSdaNext = 1'b0;
            stateNext   = S_IDLE;
          end else begin
            ctl.loadCnt = 1'b1;
            stateNext   = S_BOTH_HI;
          end
        end
      end
      S_BOTH_HI: begin
        if (!sclIn) begin
          ctl.setBcol = 1'b1;
          ctl.clrReq  = 1'b1;
          holdSdaNext = 1'b0;
          stateNext   = S_IDLE;
        end else if (timeout) begin
          ctl.loadCnt = 1'b1;
          holdSdaNext = 1'b1;
          stateNext   = S_SDA_LOW;
        end
      end
      S_SDA_LOW: begin
        if (timeout) begin
          ctl.setIrq = 1'b1;
          ctl.clrReq = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      holdSda <= 1'b0;
    end else begin
      state   <= stateNext;
      holdSda <= holdSdaNext;
    end
  end

  assign busy        = (state != S_IDLE);
  assign sclDriveLow = (state == S_PULL_SCL) || (state == S_SDA_REL);
  assign sdaDriveLow = holdSda;
endmodule

// File: rtl/rs_dp.sv
module rs_dp
  import rs_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             busy,
  input  logic             otherBusy,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             cmdWrite,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             bufWrite,
  input  logic [BUF_W-1:0] bufData,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             timeout,
  output logic [CMD_W-1:0] cmdBits,
  output logic [BUF_W-1:0] bufOut,
  output logic             startSeen,
  output logic             irqFlag,
  output logic             bcolFlag,
  output logic             wcolFlag
);
  logic [CNT_W-1:0] baudCnt;
  logic sdaPrev;
  logic startEdge;

  assign timeout   = (baudCnt == '0);
  assign startEdge = sdaPrev && !sdaIn && sclIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
    end else if (ctl.loadCnt) begin
      baudCnt <= reloadVal;
    end else if (!timeout) begin
      baudCnt <= baudCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= '0;
    end else if (ctl.clrReq) begin
      cmdBits[REQ_BIT] <= 1'b0;
    end else if (cmdWrite && !busy) begin
      cmdBits          <= cmdData;
      cmdBits[REQ_BIT] <= cmdData[REQ_BIT] && !otherBusy;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufOut <= '0;
    end else if (bufWrite && !busy) begin
      bufOut <= bufData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPrev   <= 1'b1;
      startSeen <= 1'b0;
      irqFlag   <= 1'b0;
      bcolFlag  <= 1'b0;
      wcolFlag  <= 1'b0;
    end else begin
      sdaPrev <= sdaIn;
      if (ctl.accept) begin
        startSeen <= 1'b0;
        irqFlag   <= 1'b0;
        bcolFlag  <= 1'b0;
        wcolFlag  <= 1'b0;
      end else begin
        if (startEdge)          startSeen <= 1'b1;
        if (ctl.setIrq)         irqFlag   <= 1'b1;
        if (ctl.setBcol)        bcolFlag  <= 1'b1;
        if (bufWrite && busy)   wcolFlag  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_top.sv
module rs_top
  import rs_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             otherBusy,
  input  logic             cmdWrite,
  input  logic [CMD_W-1:0] cmdData,
  output logic [CMD_W-1:0] cmdBits,
  input  logic             bufWrite,
  input  logic [BUF_W-1:0] bufData,
  output logic [BUF_W-1:0] bufOut,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             startSeen,
  output logic             irqFlag,
  output logic             bcolFlag,
  output logic             wcolFlag
);
  dpCtl_t ctl;
  logic   busy;
  logic   timeout;
  logic   reqWrite;

  assign reqWrite = cmdWrite && cmdData[REQ_BIT];

  rs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .otherBusy(otherBusy),
    .sclIn(sclIn), .sdaIn(sdaIn), .timeout(timeout), .ctl(ctl),
    .busy(busy), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  rs_dp #(.CNT_W(CNT_W), .BUF_W(BUF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .otherBusy(otherBusy),
    .reloadVal(reloadVal), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .bufWrite(bufWrite), .bufData(bufData), .sclIn(sclIn), .sdaIn(sdaIn),
    .timeout(timeout), .cmdBits(cmdBits), .bufOut(bufOut),
    .startSeen(startSeen), .irqFlag(irqFlag), .bcolFlag(bcolFlag),
    .wcolFlag(wcolFlag)
  );
endmodule

// File: rtl/rs_chk.sv
module rs_chk #(
  parameter int BUF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             otherBusy,
  input logic             cmdWrite,
  input logic [4:0]       cmdData,
  input logic [4:0]       cmdBits,
  input logic             bufWrite,
  input logic [BUF_W-1:0] bufOut,
  input logic             sclIn,
  input logic             sdaIn,
  input logic             sclDriveLow,
  input logic             sdaDriveLow,
  input logic             startSeen,
  input logic             irqFlag,
  input logic             bcolFlag,
  input logic             wcolFlag
);
  p_sda_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> !sclDriveLow);

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && otherBusy && cmdWrite && cmdData[1]) |=> !sclDriveLow);

  p_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startSeen) |-> ($past(sclIn) && !$past(sdaIn)));

  p_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> (!cmdBits[1] && sdaDriveLow && !bcolFlag));

  p_bcol_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bcolFlag) |-> (!sclDriveLow && !sdaDriveLow && !cmdBits[1] && !irqFlag));

  p_wcol_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bufWrite) |=> (wcolFlag && $stable(bufOut)));

  p_lock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite) |=> ((cmdBits | 5'b00010) == ($past(cmdBits) | 5'b00010)));
endmodule

bind rs_top rs_chk #(.BUF_W(BUF_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .otherBusy(otherBusy),
  .cmdWrite(cmdWrite), .cmdData(cmdData), .cmdBits(cmdBits),
  .bufWrite(bufWrite), .bufOut(bufOut), .sclIn(sclIn), .sdaIn(sdaIn),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .startSeen(startSeen), .irqFlag(irqFlag), .bcolFlag(bcolFlag),
  .wcolFlag(wcolFlag)
);

// File: tb/sim_rs_top.sv
`timescale 1ns/1ps
module sim_rs_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] reloadVal = 7'd3;
  logic otherBusy = 1'b0;
  logic cmdWrite = 1'b0;
  logic [4:0] cmdData = '0;
  logic [4:0] cmdBits;
  logic bufWrite = 1'b0;
  logic [7:0] bufData = '0;
  logic [7:0] bufOut;
  logic sclIn, sdaIn, sclDriveLow, sdaDriveLow;
  logic startSeen, irqFlag, bcolFlag, wcolFlag;
  logic extSclLow = 1'b0;
  logic extSdaLow = 1'b0;

  assign sclIn = !(sclDriveLow || extSclLow);
  assign sdaIn = !(sdaDriveLow || extSdaLow);

  always #2.5 clk = ~clk;

  rs_top u0 (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .otherBusy(otherBusy),
    .cmdWrite(cmdWrite), .cmdData(cmdData), .cmdBits(cmdBits),
    .bufWrite(bufWrite), .bufData(bufData), .bufOut(bufOut),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .startSeen(startSeen), .irqFlag(irqFlag),
    .bcolFlag(bcolFlag), .wcolFlag(wcolFlag)
  );

  typedef struct {
    int         k;
    logic [4:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nChecks = 0;
  int   nFails  = 0;
  int   kCnt    = 0;
  bit   mon     = 1'b0;
  bit   done    = 1'b0;
  logic [4:0] prevVec = '0;
  logic [7:0] expBuf  = '0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Vector order: {sclDriveLow, sdaDriveLow, startSeen, irqFlag, bcolFlag}
  task automatic push(int k, logic [4:0] v, string tag);
    exp_t e;
    if (q.size() > 0 && q[q.size()-1].k == k) begin
      q[q.size()-1].v   = v;
      q[q.size()-1].tag = tag;
    end else begin
      e.k = k; e.v = v; e.tag = tag;
      q.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    logic [4:0] vec;
    exp_t e;
    vec = {sclDriveLow, sdaDriveLow, startSeen, irqFlag, bcolFlag};
    if (mon && vec != prevVec) begin
      nChecks++;
      if (q.size() == 0) begin
        nFails++;
        $display("FAIL unexpected change: actual k=%0d v=%b expected none", kCnt, vec);
      end else begin
        e = q.pop_front();
        if (e.k != kCnt || e.v != vec) begin
          nFails++;
          $display("FAIL %s: actual k=%0d v=%b expected k=%0d v=%b",
                   e.tag, kCnt, vec, e.k, e.v);
        end
      end
    end
    prevVec = vec;
    if (mon) kCnt++;
  end

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startReq();
    @(negedge clk);
    cmdWrite = 1'b1;
    cmdData  = 5'b00010;
    @(posedge clk);
    #1;
    cmdWrite = 1'b0;
    kCnt     = 0;
    mon      = 1'b1;
  endtask

  task automatic endMon(string tag);
    mon = 1'b0;
    chk(tag, q.size(), 0);
    q.delete();
  endtask

  task automatic runNominal(int r, bit midWrites);
    reloadVal = 7'(r);
    push(0,       5'b10000, "R3 R11 scl low");
    push(r + 2,   5'b00000, "R3 scl release");
    push(2*r + 4, 5'b01000, "R3 sda low");
    push(2*r + 5, 5'b01100, "R5 start seen");
    push(3*r + 5, 5'b01110, "R6 done");
    startReq();
    if (midWrites) begin
      waitEdges(1);
      cmdWrite = 1'b1; cmdData = 5'b10101;
      bufWrite = 1'b1; bufData = 8'hA5;
      waitEdges(1);
      cmdWrite = 1'b0; bufWrite = 1'b0;
      chk("R10 cmd locked", cmdBits, 2);
      chk("R9 wcol set", wcolFlag, 1);
      chk("R9 buffer kept", bufOut, expBuf);
      waitEdges(3*r + 4);
    end else begin
      waitEdges(3*r + 6);
    end
    endMon("R3 R6 events");
    chk("R6 req cleared", cmdBits, 0);
    chk("R6 sda held", sdaDriveLow, 1);
  endtask

  initial begin : main
    #12;
    rstN = 1'b1;
    waitEdges(1);
    chk("R1 scl", sclDriveLow, 0);
    chk("R1 sda", sdaDriveLow, 0);
    chk("R1 flags", {startSeen, irqFlag, bcolFlag, wcolFlag}, 0);
    chk("R1 cmd", cmdBits, 0);
    chk("R1 buf", bufOut, 0);

    // R2: request ignored while another event runs
    otherBusy = 1'b1;
    @(negedge clk); cmdWrite = 1'b1; cmdData = 5'b00010;
    waitEdges(1); cmdWrite = 1'b0;
    waitEdges(3);
    chk("R2 req bit", cmdBits[1], 0);
    chk("R2 scl not driven", sclDriveLow, 0);
    otherBusy = 1'b0;

    // R3 R5 R6 R9 R10 nominal with writes during the sequence
    runNominal(3, 1'b1);
    @(negedge clk); bufWrite = 1'b1; bufData = 8'h3C;
    waitEdges(1); bufWrite = 1'b0; expBuf = 8'h3C;
    chk("R9 idle write", bufOut, 8'h3C);

    // R3 with the shortest period
    runNominal(0, 1'b0);
    chk("R11 wcol cleared", wcolFlag, 0);

    // R4 clock stretching: release after edge r+6 gives a 4 cycle shift
    reloadVal = 7'd2;
    extSclLow = 1'b1;
    push(0,      5'b10000, "R4 scl low");
    push(4,      5'b00000, "R4 scl release");
    push(8 + 4,  5'b01000, "R4 sda low");
    push(9 + 4,  5'b01100, "R4 start seen");
    push(11 + 4, 5'b01110, "R4 done");
    startReq();
    waitEdges(8);
    extSclLow = 1'b0;
    waitEdges(8);
    endMon("R4 events");

    // R7 SDA low when SCL rises
    reloadVal = 7'd4;
    push(0, 5'b10000, "R7 scl low");
    push(6, 5'b00000, "R7 scl release");
    push(7, 5'b00101, "R7 collision");
    startReq();
    waitEdges(6);
    extSdaLow = 1'b1;
    waitEdges(3);
    extSdaLow = 1'b0;
    endMon("R7 events");
    chk("R7 req cleared", cmdBits, 0);
    chk("R7 no irq", irqFlag, 0);

    // R8 SCL pulled low during the both-high period
    push(0,  5'b10000, "R8 scl low");
    push(6,  5'b00000, "R8 scl release");
    push(10, 5'b00001, "R8 collision");
    startReq();
    waitEdges(9);
    extSclLow = 1'b1;
    waitEdges(3);
    extSclLow = 1'b0;
    endMon("R8 events");
    chk("R8 req cleared", cmdBits, 0);
    chk("R8 sda released", sdaDriveLow, 0);

    waitEdges(4);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule